// File: doc/BRIEF.md
# Seeded Transmit Cipher and NRZI Serializer

This block sits in the transmit path of a 100 Mb/s twisted-pair PHY, directly after the 4B/5B encoder. It takes one 5-bit code group at a time and sends it out one bit per clock. Each bit is XORed with the output of an 11-bit stream-cipher shift register, and the resulting bit stream is converted to NRZI for the line driver. The line clock runs at the serial bit rate (125 MHz in the target PHY). A one-clock strobe tells the upstream encoder when the next code group is taken.

The cipher register can be reloaded on command. The seed joins the port's PHY address with a 6-bit user value. Each port of a multiport device can therefore run a different cipher stream, so that the ports do not all radiate the same spectrum. A seed of all zeros would freeze the register, so the block replaces it with all ones.

Top module: `tx_cipher_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets. After reset, `line_out` is 0, the cipher state is all ones, the data bit in flight is 0, and `sym_req` is high in the first cycle after reset.
- R2: `sym_req` is high for exactly one cycle in every five, and never in two consecutive cycles.
- R3: The code group on `sym_in` is taken at the rising edge where `sym_req` is high. It is sent over the next five bit times with bit 0 first and bit 4 last.
- R4: The cipher state S[10:0] produces key bit S[10] XOR S[8] in each cycle. Where no load occurs, each edge shifts S left by one and places that key bit in S[0]. S[10] is the oldest value in the recurrence x(n) = x(n-11) XOR x(n-9).
- R5: The bit sent in each cycle is the current data bit XOR the current key bit.
- R6: At each edge, `line_out` toggles if the bit sent is 1 and holds if it is 0.
- R7: At the edge where `seed_load` is high, S is loaded with the seed. `phy_addr` goes in S[10:6] and `user_seed` in S[5:0]. S does not shift at that edge, and it shifts normally from the loaded value afterwards.
- R8: A seed of all zeros loads S = all ones instead, so S is never zero.
- R9: If `seed_load` stays high, S is reloaded at every edge, so the key bit stays constant. Loading has no effect on the code-group timing or the data bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_in | input | 5 | Next code group from the encoder |
| sym_req | output | 1 | High in the cycle whose edge takes `sym_in` |
| seed_load | input | 1 | Load the cipher state from the seed at this edge |
| phy_addr | input | 5 | Port address, upper part of the seed |
| user_seed | input | 6 | User value, lower part of the seed |
| line_out | output | 1 | NRZI line level |

## Verification
The bench runs several kinds of code-group stream:
- All-zero groups expose the bare cipher sequence in the NRZI output. This separates recurrence faults from serializer faults.
- All-ones groups invert every key bit, which catches a missing XOR.
- Random groups check the bit order inside a group.

It also covers several seed cases:
- Loads with distinct addresses and user seeds show whether the fields sit in the right place.
- A zero seed shows whether the all-ones substitution is present.
- A load held for several cycles, and a load in the middle of a group, show that reloading freezes the key without disturbing the serializer.

// File: rtl/scr_pkg.sv
// Shared sizes for the transmit cipher serializer.
// Assumes the seed fields together are exactly as wide as the cipher register.
package scr_pkg;
    localparam int SYM_W   = 5;   // code-group width
    localparam int LFSR_W  = 11;  // cipher register width
    localparam int TAP_OLD = 10;  // state bit holding x(n-11)
    localparam int TAP_MID = 8;   // state bit holding x(n-9)
    localparam int ADDR_W  = 5;   // PHY address field
    localparam int USEED_W = 6;   // user seed field
    typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/seed_former.sv
// Joins the address and the user seed into one cipher seed, address on top.
// When ZERO_FIX is set, an all-zero result is replaced by all ones.
// Assumes ADDR_W + USEED_W equals the cipher width.
module seed_former #(
    parameter int ADDR_W   = 5,
    parameter int USEED_W  = 6,
    parameter bit ZERO_FIX = 1'b1
) (
    input  logic [ADDR_W-1:0]         phy_addr,
    input  logic [USEED_W-1:0]        user_seed,
    output logic [ADDR_W+USEED_W-1:0] seed_out
);
    localparam int SEED_W = ADDR_W + USEED_W;

    logic [SEED_W-1:0] joined;

    // Place the address above the user field.
    always_comb joined = {phy_addr, user_seed};

    generate
        if (ZERO_FIX) begin : g_fix
            // Substitute all ones for the lock-up value.
            always_comb seed_out = (joined == '0) ? {SEED_W{1'b1}} : joined;
        end else begin : g_raw
            // Pass the seed through unchanged.
            always_comb seed_out = joined;
        end
    endgenerate
endmodule

// File: rtl/cipher_lfsr.sv
// Stream-cipher shift register. Produces key = S[TAP_OLD] ^ S[TAP_MID].
// Shifts left and inserts the key at each edge unless a load is requested.
// Assumes the seed is never zero, which the seed former guarantees.
module cipher_lfsr #(
    parameter int W       = 11,
    parameter int TAP_OLD = 10,
    parameter int TAP_MID = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    output logic         key_bit
);
    logic [W-1:0] state;

    // Key bit for the current bit time.
    always_comb key_bit = state[TAP_OLD] ^ state[TAP_MID];

    // Reset to all ones, load the seed on request, otherwise advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= {W{1'b1}};
        else if (load)
            state <= seed;
        else
            state <= {state[W-2:0], key_bit};
    end

    // R7: the loaded value is the seed of the previous cycle.
    assert_seed_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(seed));

    // R8: the register never holds the lock-up value.
    assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/sym_serializer.sv
// Takes one code group when the request is high and shifts it out LSB first.
// The request is decoded from the bit counter on the last bit of a group.
// Assumes upstream holds a valid group on sym_in whenever sym_req is high.
module sym_serializer #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    output logic             data_bit,
    output logic             sym_req
);
    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [SYM_W-1:0] shreg;

    // Request on the last bit time of the group in flight.
    always_comb sym_req = (bit_cnt == LAST);

    // Current data bit is the low end of the shift register.
    always_comb data_bit = shreg[0];

    // Count bit times and either take a new group or shift right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= LAST;
            shreg   <= '0;
        end else if (sym_req) begin
            bit_cnt <= '0;
            shreg   <= sym_in;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {1'b0, shreg[SYM_W-1:1]};
        end
    end

    // R2: the request never lasts two cycles.
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_req |=> !sym_req);

    // R3: the first bit sent after a take is bit 0 of the taken group.
    assert_lsb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_req |=> data_bit == $past(sym_in[0]));
endmodule

// File: rtl/nrzi_encoder.sv
// NRZ to NRZI: the line level toggles for a 1 and holds for a 0.
// Assumes one input bit per clock.
module nrzi_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic line_out
);
    // Hold or toggle the line level; level 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_out <= 1'b0;
        else
            line_out <= line_out ^ bit_in;
    end

    // R6: a zero bit keeps the level.
    assert_hold_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> $stable(line_out));

    // R6: a one bit changes the level.
    assert_toggle_on_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> line_out != $past(line_out));
endmodule

// File: rtl/tx_cipher_serializer.sv
// Transmit stage: serializes 5-bit groups, XORs each bit with the cipher key
// and drives an NRZI line. The seed for the cipher comes from address and user seed.
// Assumes one clock per line bit and synchronous active-low reset.
module tx_cipher_serializer
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_in,
    output logic              sym_req,
    input  logic              seed_load,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [USEED_W-1:0] user_seed,
    output logic              line_out
);
    lfsr_t seed;
    logic  data_bit;
    logic  key_bit;
    logic  tx_bit;

    seed_former #(
        .ADDR_W  (ADDR_W),
        .USEED_W (USEED_W),
        .ZERO_FIX(1'b1)
    ) u_seed (
        .phy_addr (phy_addr),
        .user_seed(user_seed),
        .seed_out (seed)
    );

    cipher_lfsr #(
        .W      (LFSR_W),
        .TAP_OLD(TAP_OLD),
        .TAP_MID(TAP_MID)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (seed_load),
        .seed   (seed),
        .key_bit(key_bit)
    );

    sym_serializer #(
        .SYM_W(SYM_W)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_in  (sym_in),
        .data_bit(data_bit),
        .sym_req (sym_req)
    );

    // Cipher the data bit in flight.
    always_comb tx_bit = data_bit ^ key_bit;

    nrzi_encoder u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (tx_bit),
        .line_out(line_out)
    );
endmodule

// File: tb/sim_tx_cipher_serializer.sv
// Bench with a behavioural reference: bit queues for the data and the
// recurrence history, compared with the ports on every clock.
module sim_tx_cipher_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sym_in = '0;
    logic       seed_load = 1'b0;
    logic [4:0] phy_addr = '0;
    logic [5:0] user_seed = '0;
    logic       sym_req;
    logic       line_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit primed = 0;

    // Reference state: data bits still to send, recurrence history (index 0 oldest), line.
    bit m_q[$];
    bit m_h[$];
    bit m_line;

    always #10 clk = ~clk;

    tx_cipher_serializer u0 (
        .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .sym_req(sym_req),
        .seed_load(seed_load), .phy_addr(phy_addr), .user_seed(user_seed),
        .line_out(line_out)
    );

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare ports at the falling edge, drive inputs, advance the reference for the next edge.
    task automatic cycle(input bit rst, input logic [4:0] s, input bit ld,
                         input logic [4:0] pa, input logic [5:0] us, input string tag);
        if (primed) begin
            check_bit(tag, "line_out", line_out, m_line);
            check_bit((m_q.size() == 1) ? tag : "R2", "sym_req", sym_req, m_q.size() == 1);
        end
        rst_n = !rst; sym_in = s; seed_load = ld; phy_addr = pa; user_seed = us;
        if (rst) begin
            m_q = {1'b0};
            m_h.delete();
            for (int i = 0; i < 11; i++) m_h.push_back(1'b1);
            m_line = 0;
        end else begin
            bit k = m_h[0] ^ m_h[2];
            m_line = m_line ^ (m_q[0] ^ k);
            if (m_q.size() == 1) begin
                m_q.delete();
                for (int i = 0; i < 5; i++) m_q.push_back(s[i]);
            end else void'(m_q.pop_front());
            if (ld) begin
                logic [10:0] sd = {pa, us};
                if (sd == '0) sd = '1;
                m_h.delete();
                for (int i = 0; i < 11; i++) m_h.push_back(sd[10-i]);
            end else begin
                void'(m_h.pop_front());
                m_h.push_back(k);
            end
        end
        @(posedge clk); @(negedge clk);
        primed = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (3) cycle(1, 5'h0, 0, 5'h0, 6'h0, "R1");
        cycle(0, 5'h0, 0, 5'h0, 6'h0, "R1");
        // R4: zero data shows the bare cipher stream from the all-ones state
        for (int i = 0; i < 60; i++) cycle(0, 5'h00, 0, 5'h0, 6'h0, "R4");
        // R5: all-ones data inverts each key bit
        for (int i = 0; i < 40; i++) cycle(0, 5'h1F, 0, 5'h0, 6'h0, "R5");
        // R3 / R6: random groups, bit order and NRZI
        for (int i = 0; i < 200; i++) cycle(0, 5'($urandom), 0, 5'h0, 6'h0, "R3");
        // R7: seed loads with distinct fields
        cycle(0, 5'h0A, 1, 5'h13, 6'h2A, "R7");
        for (int i = 0; i < 40; i++) cycle(0, 5'h00, 0, 5'h13, 6'h2A, "R7");
        cycle(0, 5'h00, 1, 5'h01, 6'h00, "R7");
        for (int i = 0; i < 40; i++) cycle(0, 5'h00, 0, 5'h0, 6'h0, "R7");
        cycle(0, 5'h00, 1, 5'h00, 6'h01, "R7");
        for (int i = 0; i < 40; i++) cycle(0, 5'h00, 0, 5'h0, 6'h0, "R7");
        // R8: zero seed becomes all ones
        cycle(0, 5'h00, 1, 5'h00, 6'h00, "R8");
        for (int i = 0; i < 60; i++) cycle(0, 5'h00, 0, 5'h0, 6'h0, "R8");
        // R9: held load freezes the key, group timing unchanged
        for (int i = 0; i < 12; i++) cycle(0, 5'($urandom), 1, 5'h15, 6'h33, "R9");
        for (int i = 0; i < 7; i++) cycle(0, 5'($urandom), 0, 5'h0, 6'h0, "R9");
        cycle(0, 5'h16, 1, 5'h07, 6'h19, "R9");
        for (int i = 0; i < 30; i++) cycle(0, 5'($urandom), 0, 5'h0, 6'h0, "R9");
        // R1: reset in mid-stream
        cycle(1, 5'h1F, 0, 5'h0, 6'h0, "R1");
        for (int i = 0; i < 20; i++) cycle(0, 5'($urandom), 0, 5'h0, 6'h0, "R1");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule